// File: doc/BRIEF.md
# Handshaked Word Memory Responder

This block is the memory side of a simple processor bus. When the strobe is high at a clock edge, the block takes the address and the read/not-write line and starts one access. A write stores the data word in the same edge and raises no completion flag. A read counts a fixed number of cycles, then places the addressed word on the read data output and raises a fetch-complete flag. The flag stays high until the next strobe that the block accepts.

Storage is a set of 32-bit words. Word n sits at byte address 4n, and the two low address bits take no part in selecting a word. The read latency is a parameter worked out at elaboration. With no raw delay given it is two cycles. Otherwise it is the raw memory delay divided by the clock period, rounded up. A testbench can load words directly through a separate backdoor write port. A strobe that arrives while a read is still counting is a protocol violation, and the block drops it.

Top module: `word_mem_responder`

## Requirements
- R1: While reset is low and after it is released, `mfc` is 0 and `rdata` is 0.
- R2: A read is accepted when `strobe` is 1 and `rd_nwr` is 1 at a rising edge k with no read pending. `mfc` is then 0 after edges k through k+L-1 and becomes 1 after edge k+L, where L is the read latency.
- R3: L is 2 when `RAW_DELAY` is 0. Otherwise L is ceil(`RAW_DELAY`/`CLK_PERIOD`), with a minimum of 1. For example, a delay of 100 with a period of 35 gives 3.
- R4: An accepted strobe with `rd_nwr` equal to 0 stores `wdata` into the addressed word at that same edge, and `mfc` stays 0 afterwards. A read issued in the next cycle returns the new word.
- R5: Once `mfc` is 1 it stays 1 until the next accepted strobe, which clears it at that edge.
- R6: A strobe that arrives while a read is pending is ignored. It starts no read, writes nothing, and neither restarts nor stretches the current latency count.
- R7: Word selection uses only `addr[ADDR_W-1:2]`, so `addr[1:0]` has no effect on which word is read or written.
- R8: When `bd_we` is 1 at an edge, `bd_wdata` is stored at word index `bd_idx`. A later bus read of byte address 4*`bd_idx` returns it.
- R9: When `mfc` rises, `rdata` holds the word read. It does not change except when a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Access request, sampled at the clock edge |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Byte address; the low two bits are ignored |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Data from the last completed read |
| mfc | output | 1 | Fetch-complete flag |
| bd_we | input | 1 | Backdoor write enable |
| bd_idx | input | ADDR_W-2 | Backdoor word index |
| bd_wdata | input | DATA_W | Backdoor write data |

## Verification
The hardest case to reach is a strobe that lands during the read countdown. A well-behaved master never sends one, so random traffic that waits for `mfc` never produces it. Directed sequences therefore issue a read and then, one edge later, raise the strobe again, once as a write to a different word and once as a read. The bench then checks that `mfc` still rises on the original edge, that `rdata` holds the original word, and that the target of the dropped write is unchanged when read back. A second instance with a raw delay of 100 and a period of 35 runs the same first read so that the derived latency of 3 is checked.

// File: rtl/wmr_pkg.sv
package wmr_pkg;
  localparam int DEFAULT_LAT = 2;

  // Read latency in cycles: ceiling of raw delay over clock period.
  function automatic int calc_lat(input int raw_delay, input int clk_period);
    int lat;
    if (raw_delay <= 0 || clk_period <= 0) lat = DEFAULT_LAT;
    else lat = (raw_delay + clk_period - 1) / clk_period;
    if (lat < 1) lat = 1;
    return lat;
  endfunction
endpackage

// File: rtl/wmr_store.sv
module wmr_store #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bd_we,
  input  logic [IDX_W-1:0]  bd_idx,
  input  logic [DATA_W-1:0] bd_wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [DATA_W-1:0] words [DEPTH];

  // One write-enable decode per word; the backdoor wins on a collision.
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic bd_hit, bus_hit;
    assign bd_hit  = bd_we  && (bd_idx  == IDX_W'(g));
    assign bus_hit = bus_we && (bus_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (bd_hit)       words[g] <= bd_wdata;
      else if (bus_hit) words[g] <= bus_wdata;
    end
  end

  assign rd_word = words[rd_idx];
endmodule

// File: rtl/wmr_timer.sv
module wmr_timer #(
  parameter int LAT   = 2,
  parameter int CNT_W = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic start_rd,
  output logic pending,
  output logic done,
  output logic mfc
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             mfc_q, mfc_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    mfc_d  = mfc_q;
    done   = 1'b0;
    if (pend_q) begin
      if (cnt_q == '0) begin
        pend_d = 1'b0;
        mfc_d  = 1'b1;
        done   = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (accept) begin
      mfc_d = 1'b0;
      if (start_rd) begin
        pend_d = 1'b1;
        cnt_d  = CNT_W'(LAT - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      mfc_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      mfc_q  <= mfc_d;
    end
  end

  assign pending = pend_q;
  assign mfc     = mfc_q;

  // R2: the flag is never up while a read is still counting
  p_flag_not_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !mfc_q);
  // R2: the flag only rises at the end of a pending read
  p_rise_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mfc_q) |-> $past(pend_q));
  // R5: the flag holds until an accepted strobe
  p_flag_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mfc_q && !accept |=> mfc_q);
  // R5: an accepted strobe clears the flag
  p_accept_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !mfc_q);
endmodule

// File: rtl/word_mem_responder.sv
module word_mem_responder #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int RAW_DELAY  = 0,
  parameter int CLK_PERIOD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              mfc,
  input  logic              bd_we,
  input  logic [ADDR_W-3:0] bd_idx,
  input  logic [DATA_W-1:0] bd_wdata
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int RD_LAT = wmr_pkg::calc_lat(RAW_DELAY, CLK_PERIOD);
  localparam int CNT_W  = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;

  logic             pending, done, accept, start_rd, bus_we;
  logic [IDX_W-1:0] word_idx, rd_idx_q;
  logic [DATA_W-1:0] rd_word, rdata_q;
  logic             unused_lo_bits;

  assign unused_lo_bits = ^addr[1:0];
  assign word_idx = addr[ADDR_W-1:2];
  assign accept   = strobe && !pending;
  assign start_rd = accept && rd_nwr;
  assign bus_we   = accept && !rd_nwr;

  wmr_timer #(.LAT(RD_LAT), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .accept(accept), .start_rd(start_rd),
    .pending(pending), .done(done), .mfc(mfc)
  );

  wmr_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .bus_we(bus_we), .bus_idx(word_idx), .bus_wdata(wdata),
    .bd_we(bd_we), .bd_idx(bd_idx), .bd_wdata(bd_wdata),
    .rd_idx(rd_idx_q), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_idx_q <= '0;
    else if (start_rd) rd_idx_q <= word_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (done) rdata_q <= rd_word;
  end

  assign rdata = rdata_q;

  // R6: a strobe during a pending read never writes storage
  p_busy_blocks_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && pending |-> !bus_we);
  // R9: read data moves only when a read completes
  p_rdata_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rdata_q));
  // R4: a write never raises the flag
  p_write_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> !mfc);
endmodule

// File: tb/word_mem_responder_tb.sv
module word_mem_responder_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NW     = 64;
  localparam int LAT_A  = 2;
  localparam int LAT_B  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, rd_nwr = 1'b1, bd_we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, bd_wdata = '0;
  logic [ADDR_W-3:0] bd_idx = '0;
  logic [DATA_W-1:0] rdata, rdata_b;
  logic mfc, mfc_b;

  int n_tests = 0, n_fail = 0;
  logic finished = 1'b0;
  logic [DATA_W-1:0] model_mem [NW];
  logic [DATA_W-1:0] last_rd = '0;

  always #2 clk = ~clk;

  word_mem_responder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rd_nwr(rd_nwr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mfc(mfc), .bd_we(bd_we), .bd_idx(bd_idx),
    .bd_wdata(bd_wdata));

  word_mem_responder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAW_DELAY(100),
    .CLK_PERIOD(35)) u_dut_slow (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rd_nwr(rd_nwr), .addr(addr),
    .wdata(wdata), .rdata(rdata_b), .mfc(mfc_b), .bd_we(bd_we), .bd_idx(bd_idx),
    .bd_wdata(bd_wdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] byte_addr(input int idx, input logic [1:0] lo);
    return {6'(idx), lo};
  endfunction

  task automatic do_read(input int idx, input logic [1:0] lo);
    strobe = 1'b1; rd_nwr = 1'b1; addr = byte_addr(idx, lo);
    for (int n = 1; n <= LAT_A + 1; n++) begin
      @(negedge clk);
      strobe = 1'b0;
      check((n == LAT_A + 1) ? "R2 mfc rise" : "R2 mfc low", 32'(mfc),
            32'(n == LAT_A + 1));
    end
    check((lo != 2'b00) ? "R7 rdata low bits" : "R2 rdata", rdata, model_mem[idx]);
    last_rd = model_mem[idx];
  endtask

  task automatic do_write(input int idx, input logic [1:0] lo, input logic [31:0] d);
    strobe = 1'b1; rd_nwr = 1'b0; addr = byte_addr(idx, lo); wdata = d;
    @(negedge clk);
    strobe = 1'b0; rd_nwr = 1'b1;
    model_mem[idx] = d;
    check("R4 no mfc after write", 32'(mfc), 32'd0);
    check("R9 rdata held over write", rdata, last_rd);
  endtask

  task automatic busy_strobe(input logic second_is_read);
    strobe = 1'b1; rd_nwr = 1'b1; addr = byte_addr(5, 2'b00);
    @(negedge clk);
    strobe = 1'b1; rd_nwr = ~second_is_read; addr = byte_addr(9, 2'b00);
    wdata = 32'hDEAD_0000 | 32'(second_is_read);
    @(negedge clk);
    strobe = 1'b0; rd_nwr = 1'b1;
    check("R6 no early mfc", 32'(mfc), 32'd0);
    @(negedge clk);
    check("R6 latency kept", 32'(mfc), 32'd1);
    check("R6 original data", rdata, model_mem[5]);
    last_rd = model_mem[5];
    @(negedge clk);
    check("R5 mfc held", 32'(mfc), 32'd1);
    do_read(9, 2'b00);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 mfc in reset", 32'(mfc), 32'd0);
    check("R1 rdata in reset", rdata, 32'd0);
    // R8: preload via backdoor
    for (int i = 0; i < NW; i++) begin
      bd_we = 1'b1; bd_idx = 6'(i); bd_wdata = 32'h1000_0000 + 32'(i * 7);
      model_mem[i] = bd_wdata;
      @(negedge clk);
    end
    bd_we = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mfc after reset", 32'(mfc), 32'd0);
    check("R1 rdata after reset", rdata, 32'd0);

    // R3: both instances from the same strobe
    strobe = 1'b1; rd_nwr = 1'b1; addr = byte_addr(3, 2'b00);
    for (int n = 1; n <= LAT_B + 1; n++) begin
      @(negedge clk);
      strobe = 1'b0;
      check("R3 default latency", 32'(mfc), 32'(n >= LAT_A + 1));
      check("R3 derived latency", 32'(mfc_b), 32'(n == LAT_B + 1));
    end
    check("R3 slow rdata", rdata_b, model_mem[3]);
    check("R8 backdoor word", rdata, model_mem[3]);
    last_rd = model_mem[3];

    // R5: flag stays up over idle cycles, cleared by the next strobe
    repeat (4) @(negedge clk);
    check("R5 mfc held idle", 32'(mfc), 32'd1);
    do_write(12, 2'b11, 32'hCAFE_F00D);
    do_read(12, 2'b01);
    do_read(12, 2'b10);

    // R8: backdoor write after operation
    bd_we = 1'b1; bd_idx = 6'd40; bd_wdata = 32'h0BAD_BEEF; model_mem[40] = bd_wdata;
    @(negedge clk);
    bd_we = 1'b0;
    do_read(40, 2'b00);

    // R6: strobes while busy
    busy_strobe(1'b0);
    busy_strobe(1'b1);

    // Boundary words
    do_write(0, 2'b00, 32'hFFFF_FFFF);
    do_write(NW - 1, 2'b11, 32'h0000_0001);
    do_read(0, 2'b11);
    do_read(NW - 1, 2'b00);

    // Random traffic
    for (int k = 0; k < 300; k++) begin
      int idx;
      logic [1:0] lo;
      idx = int'($urandom_range(NW - 1));
      lo  = 2'($urandom_range(3));
      if ($urandom_range(1) == 0) do_write(idx, lo, $urandom);
      else do_read(idx, lo);
      repeat ($urandom_range(2)) @(negedge clk);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule